// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block keeps every in-flight memory operation of an out-of-order core in a single age-ordered ring. Each ring slot records whether the operation reads memory, writes memory, or is a soft barrier. A barrier is any operation that reads or writes memory and also has side effects. The block does not compare addresses. It decides from the age order alone whether each held operation may be sent to memory yet. A global no-alias flag relaxes one of the rules. The flag is normally tied high, which is its default setting.

Dispatch allocates a slot and receives its tag. The memory pipeline reports through the tag when an operation has been sent and when it has finished. The block exports one "may issue" bit per slot. It retires finished operations strictly oldest first, one per cycle. Capacity is split between a read-side budget and a write-side budget of configurable size, and each budget has its own full flag. A barrier never issues. It counts as finished in the first cycle in which it is the oldest held entry.

Top module: `mq_ordering_queue`

## Requirements
- R1: An allocation request carries three bits: reads (`alloc_ld`), writes (`alloc_st`) and side effects (`alloc_se`). With `alloc_se`=1 the entry is a barrier: a read barrier, a write barrier, or both, according to the two other bits. A request with neither `alloc_ld` nor `alloc_st` set is refused. Accepted entries get tags 0, 1, 2, … in acceptance order, wrapping modulo NSLOT. Tag 0 is the first tag after reset.
- R2: Each entry with `alloc_ld`=1 uses one read-budget place, and each entry with `alloc_st`=1 uses one write-budget place. `lq_full` / `sq_full` is high when its budget is used up. A request that needs a full budget is refused. A request that needs only the other budget is still accepted.
- R3: A writing operation is never allowed while an older, unfinished entry that writes is held. This covers write operations and write or full barriers.
- R4: A writing operation is never allowed while an older, unfinished read operation is held, whatever the value of `no_alias`. An older read-only barrier does not hold back a write.
- R5: A read operation may overtake an older, unfinished read only if no entry that writes and no barrier is held between the two.
- R6: A read operation may overtake an older, unfinished write operation only when `no_alias`=1.
- R7: A read operation waits for every older, unfinished read or full barrier.
- R8: A barrier never shows `can_issue`. A barrier counts as finished in the first cycle in which it is the oldest entry. It is freed in that cycle, and younger entries see it as finished in that same cycle.
- R9: The oldest entry is freed once it has finished, at most one entry per cycle, in tag order. `free_valid`/`free_tag` report the entry freed at the coming clock edge. A finished younger entry is not freed while an older one is held.
- R10: An issue notification is taken only for a slot whose `can_issue` is high, and that bit then drops. A completion notification is taken only for a slot that has issued. Other notifications have no effect.
- R11: A budget size parameter of zero is replaced by `DEF_DEPTH`.
- R12: After reset the ring is empty: no full flag, no `can_issue` bit and no `free_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| no_alias | input | 1 | Global no-alias mode: reads may overtake older writes |
| alloc_valid | input | 1 | Allocation request from dispatch |
| alloc_ld | input | 1 | Entry reads memory |
| alloc_st | input | 1 | Entry writes memory |
| alloc_se | input | 1 | Entry has side effects (makes it a barrier) |
| alloc_ok | output | 1 | Request accepted this cycle |
| alloc_tag | output | TAGW | Tag given to the accepted entry |
| lq_full | output | 1 | Read budget used up |
| sq_full | output | 1 | Write budget used up |
| issue_valid | input | 1 | Operation sent to memory |
| issue_tag | input | TAGW | Tag of the sent operation |
| done_valid | input | 1 | Operation finished |
| done_tag | input | TAGW | Tag of the finished operation |
| can_issue | output | NSLOT | Per-slot permission to issue |
| free_valid | output | 1 | Oldest entry freed at the coming edge |
| free_tag | output | TAGW | Tag of the freed entry |

## Verification
A wrong age or finished flag first appears on `can_issue`. The effect shows up in the cycle after the allocation or notification that set the flag. It shows as a write or read that is released too early or held too long, depending on which older entry was mis-recorded. A corrupted head pointer or count shows up at once as out-of-order `free_tag` values, as wrong `alloc_tag` values, or as a full flag that does not match the mix of entries allocated. A barrier that is mis-handled either never leaves the head, so `free_valid` stays low, or releases younger reads before it reaches the head.

// File: rtl/mq_pkg.sv
// Shared slot record for the memory ordering queue.
package mq_pkg;
    // One ring slot: held flag, class bits and progress bits.
    typedef struct packed {
        logic vld;   // slot holds an entry
        logic ld;    // entry reads memory
        logic st;    // entry writes memory
        logic bar;   // entry is a soft barrier
        logic iss;   // entry has been sent to memory
        logic exe;   // entry has finished
    } mq_slot_t;
endpackage

// File: rtl/mq_class_counter.sv
// Occupancy counter for one capacity budget (read side or write side).
// Assumes the caller never increments when full and never decrements at zero.
module mq_class_counter #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic full
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt;

    // Track how many places of this budget are in use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // Report the budget as exhausted.
    always_comb full = (cnt == CW'(DEPTH));
endmodule

// File: rtl/mq_age_matrix.sv
// Relative-age matrix of the ring. Bit (i*NSLOT + j) is set when slot j holds
// an entry that is older than slot i. Age is the distance from the head pointer.
// Assumes held entries are contiguous from the head.
module mq_age_matrix #(
    parameter int NSLOT = 8,
    parameter int TAGW  = 3
) (
    input  logic [NSLOT-1:0]       vld,
    input  logic [TAGW-1:0]        head,
    output logic [NSLOT*NSLOT-1:0] older_flat
);
    localparam int RW = TAGW + 1;

    logic [RW-1:0] rel [NSLOT];

    // Distance of each slot from the head, modulo the ring size.
    for (genvar i = 0; i < NSLOT; i++) begin : g_rel
        assign rel[i] = (RW'(i) >= {1'b0, head}) ? (RW'(i) - {1'b0, head})
                                                 : (RW'(i) + RW'(NSLOT) - {1'b0, head});
    end

    // Pairwise older-than comparison.
    for (genvar i = 0; i < NSLOT; i++) begin : g_row
        for (genvar j = 0; j < NSLOT; j++) begin : g_col
            assign older_flat[i*NSLOT + j] = vld[j] && (rel[j] < rel[i]);
        end
    end
endmodule

// File: rtl/mq_order_eval.sv
// Ordering rules: computes per-slot issue permission and the effective
// finished state (a barrier counts as finished once it sits at the head).
// Assumes older_flat comes from mq_age_matrix for the same head.
module mq_order_eval
    import mq_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int TAGW  = 3
) (
    input  mq_slot_t [NSLOT-1:0]   slots,
    input  logic [TAGW-1:0]        head,
    input  logic [NSLOT*NSLOT-1:0] older_flat,
    input  logic                   no_alias,
    output logic [NSLOT-1:0]       can_issue,
    output logic [NSLOT-1:0]       done_eff
);
    logic [NSLOT-1:0] vld, ld_op, st_op, ld_bar, st_any, pend, sep;
    logic [NSLOT-1:0] blk_st, blk_ld;

    // Class vectors and effective finished state per slot.
    for (genvar k = 0; k < NSLOT; k++) begin : g_cls
        assign vld[k]      = slots[k].vld;
        assign ld_op[k]    = slots[k].vld && slots[k].ld && !slots[k].bar;
        assign st_op[k]    = slots[k].vld && slots[k].st && !slots[k].bar;
        assign ld_bar[k]   = slots[k].vld && slots[k].ld && slots[k].bar;
        assign st_any[k]   = slots[k].vld && slots[k].st;
        assign done_eff[k] = slots[k].vld &&
                             (slots[k].exe || (slots[k].bar && (head == TAGW'(k))));
    end

    assign pend = vld & ~done_eff;

    // A writer or barrier separates reads when some unfinished read is older than it.
    for (genvar k = 0; k < NSLOT; k++) begin : g_sep
        assign sep[k] = vld[k] && (slots[k].st || slots[k].bar) &&
                        (|(older_flat[k*NSLOT +: NSLOT] & pend & ld_op));
    end

    // Blocking conditions and the resulting permission per slot.
    for (genvar i = 0; i < NSLOT; i++) begin : g_perm
        logic [NSLOT-1:0] row;
        assign row       = older_flat[i*NSLOT +: NSLOT];
        assign blk_st[i] = |(row & pend & (ld_op | st_any));
        assign blk_ld[i] = (|(row & pend & (ld_bar | (st_op & {NSLOT{!no_alias}})))) ||
                           (|(row & sep));
        assign can_issue[i] = slots[i].vld && !slots[i].bar && !slots[i].iss &&
                              !(st_op[i] && blk_st[i]) && !(ld_op[i] && blk_ld[i]);
    end
endmodule

// File: rtl/mq_ordering_queue.sv
// Age-ordered ring of in-flight memory operations with per-slot issue
// permission, read/write budgets and in-order freeing of finished entries.
// Assumes the issue and completion tags name slots handed out by this block.
module mq_ordering_queue
    import mq_pkg::*;
#(
    parameter int LQ_CFG    = 4,
    parameter int SQ_CFG    = 4,
    parameter int DEF_DEPTH = 4,
    localparam int LQ_DEPTH = (LQ_CFG == 0) ? DEF_DEPTH : LQ_CFG,
    localparam int SQ_DEPTH = (SQ_CFG == 0) ? DEF_DEPTH : SQ_CFG,
    localparam int NSLOT    = LQ_DEPTH + SQ_DEPTH,
    localparam int TAGW     = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             no_alias,
    input  logic             alloc_valid,
    input  logic             alloc_ld,
    input  logic             alloc_st,
    input  logic             alloc_se,
    output logic             alloc_ok,
    output logic [TAGW-1:0]  alloc_tag,
    output logic             lq_full,
    output logic             sq_full,
    input  logic             issue_valid,
    input  logic [TAGW-1:0]  issue_tag,
    input  logic             done_valid,
    input  logic [TAGW-1:0]  done_tag,
    output logic [NSLOT-1:0] can_issue,
    output logic             free_valid,
    output logic [TAGW-1:0]  free_tag
);
    mq_slot_t [NSLOT-1:0]   slots;
    logic [TAGW-1:0]        head;
    logic [TAGW:0]          count;
    logic [TAGW:0]          tail_sum;
    logic [TAGW-1:0]        tail;
    logic [NSLOT-1:0]       vld_vec;
    logic [NSLOT-1:0]       bar_mask;
    logic [NSLOT-1:0]       done_eff;
    logic [NSLOT*NSLOT-1:0] older_flat;
    logic                   pop;
    mq_slot_t               head_slot;
    mq_slot_t               new_slot;

    // Next tag in ring order.
    function automatic logic [TAGW-1:0] inc_tag(input logic [TAGW-1:0] t);
        return (t == TAGW'(NSLOT - 1)) ? '0 : t + TAGW'(1);
    endfunction

    // Tail position: head plus occupancy, folded into the ring.
    always_comb begin
        tail_sum = {1'b0, head} + count;
        tail     = (tail_sum >= (TAGW+1)'(NSLOT)) ? TAGW'(tail_sum - (TAGW+1)'(NSLOT))
                                                  : TAGW'(tail_sum);
    end

    // Accept a request that names a class and fits both budgets it needs.
    always_comb begin
        alloc_ok  = alloc_valid && (alloc_ld || alloc_st) &&
                    !(alloc_ld && lq_full) && !(alloc_st && sq_full);
        alloc_tag = tail;
        new_slot  = '{vld: 1'b1, ld: alloc_ld, st: alloc_st, bar: alloc_se,
                      iss: 1'b0, exe: 1'b0};
    end

    // Free the head entry once it has effectively finished.
    always_comb begin
        head_slot  = slots[head];
        pop        = head_slot.vld && done_eff[head];
        free_valid = pop;
        free_tag   = head;
    end

    // Flatten held and barrier flags for the evaluators and the checker.
    for (genvar k = 0; k < NSLOT; k++) begin : g_vec
        assign vld_vec[k]  = slots[k].vld;
        assign bar_mask[k] = slots[k].vld && slots[k].bar;
    end

    mq_age_matrix #(.NSLOT(NSLOT), .TAGW(TAGW)) u_age (
        .vld        (vld_vec),
        .head       (head),
        .older_flat (older_flat)
    );

    mq_order_eval #(.NSLOT(NSLOT), .TAGW(TAGW)) u_eval (
        .slots      (slots),
        .head       (head),
        .older_flat (older_flat),
        .no_alias   (no_alias),
        .can_issue  (can_issue),
        .done_eff   (done_eff)
    );

    mq_class_counter #(.DEPTH(LQ_DEPTH)) u_lq_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (alloc_ok && alloc_ld),
        .dec   (pop && head_slot.ld),
        .full  (lq_full)
    );

    mq_class_counter #(.DEPTH(SQ_DEPTH)) u_sq_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (alloc_ok && alloc_st),
        .dec   (pop && head_slot.st),
        .full  (sq_full)
    );

    // Slot storage: allocate at tail, clear at head, record issue and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots <= '0;
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (alloc_ok && (tail == TAGW'(i))) begin
                    slots[i] <= new_slot;
                end else if (pop && (head == TAGW'(i))) begin
                    slots[i] <= '0;
                end else begin
                    if (issue_valid && (issue_tag == TAGW'(i)) && can_issue[i])
                        slots[i].iss <= 1'b1;
                    if (done_valid && (done_tag == TAGW'(i)) && slots[i].vld &&
                        slots[i].iss && !slots[i].bar)
                        slots[i].exe <= 1'b1;
                end
            end
        end
    end

    // Head pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            count <= '0;
        end else begin
            if (pop) head <= inc_tag(head);
            case ({alloc_ok, pop})
                2'b10:   count <= count + (TAGW+1)'(1);
                2'b01:   count <= count - (TAGW+1)'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mq_ordering_queue_chk.sv
// Protocol checker for mq_ordering_queue, attached by bind below.
module mq_ordering_queue_chk #(
    parameter int NSLOT = 8,
    parameter int TAGW  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_ok,
    input logic [TAGW-1:0]  alloc_tag,
    input logic             lq_full,
    input logic             sq_full,
    input logic             issue_valid,
    input logic [TAGW-1:0]  issue_tag,
    input logic [NSLOT-1:0] can_issue,
    input logic             free_valid,
    input logic [TAGW-1:0]  free_tag,
    input logic [NSLOT-1:0] bar_mask
);
    function automatic logic [TAGW-1:0] nxt(input logic [TAGW-1:0] t);
        return (t == TAGW'(NSLOT - 1)) ? '0 : t + TAGW'(1);
    endfunction

    // R1: tags are handed out in ring order.
    a_r1_tag_sequence: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ok |=> (alloc_tag == nxt($past(alloc_tag))));

    // R2: a full read budget stays full until an entry is freed.
    a_r2_lq_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_full && !free_valid) |=> lq_full);

    // R2: a full write budget stays full until an entry is freed.
    a_r2_sq_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_full && !free_valid) |=> sq_full);

    // R8: a barrier never carries issue permission.
    a_r8_barrier_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_mask & can_issue) == '0);

    // R9: back-to-back frees follow tag order.
    a_r9_free_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |=> (!free_valid || (free_tag == nxt($past(free_tag)))));

    // R10: an accepted issue removes that slot's permission.
    a_r10_issue_once: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && can_issue[issue_tag]) |=> !can_issue[$past(issue_tag)]);
endmodule

bind mq_ordering_queue mq_ordering_queue_chk #(.NSLOT(NSLOT), .TAGW(TAGW)) u_chk (.*);

// File: tb/mq_ordering_queue_bench.sv
module mq_ordering_queue_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       no_alias = 1'b1;
    logic       a_valid = 0, a_ld = 0, a_st = 0, a_se = 0;
    logic       alloc_ok;
    logic [2:0] alloc_tag;
    logic       lq_full, sq_full;
    logic       issue_valid = 0, done_valid = 0;
    logic [2:0] issue_tag = 0, done_tag = 0;
    logic [7:0] can_issue;
    logic       free_valid;
    logic [2:0] free_tag;

    logic       z_valid = 0, z_ld = 0;
    logic       z_ok, z_lq_full, z_sq_full, z_free_valid;
    logic [2:0] z_tag, z_free_tag;
    logic [4:0] z_can;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mq_ordering_queue #(.LQ_CFG(4), .SQ_CFG(4), .DEF_DEPTH(4)) u_mq_ordering_queue (
        .clk(clk), .rst_n(rst_n), .no_alias(no_alias),
        .alloc_valid(a_valid), .alloc_ld(a_ld), .alloc_st(a_st), .alloc_se(a_se),
        .alloc_ok(alloc_ok), .alloc_tag(alloc_tag), .lq_full(lq_full), .sq_full(sq_full),
        .issue_valid(issue_valid), .issue_tag(issue_tag),
        .done_valid(done_valid), .done_tag(done_tag),
        .can_issue(can_issue), .free_valid(free_valid), .free_tag(free_tag));

    mq_ordering_queue #(.LQ_CFG(0), .SQ_CFG(2), .DEF_DEPTH(3)) u_zero (
        .clk(clk), .rst_n(rst_n), .no_alias(1'b1),
        .alloc_valid(z_valid), .alloc_ld(z_ld), .alloc_st(1'b0), .alloc_se(1'b0),
        .alloc_ok(z_ok), .alloc_tag(z_tag), .lq_full(z_lq_full), .sq_full(z_sq_full),
        .issue_valid(1'b0), .issue_tag(3'd0), .done_valid(1'b0), .done_tag(3'd0),
        .can_issue(z_can), .free_valid(z_free_valid), .free_tag(z_free_tag));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic put(input bit ld, input bit st, input bit se, output bit ok, output int tag);
        a_valid = 1; a_ld = ld; a_st = st; a_se = se;
        #1;
        ok = alloc_ok;
        tag = int'(alloc_tag);
        @(negedge clk);
        a_valid = 0; a_ld = 0; a_st = 0; a_se = 0;
        #1;
    endtask

    task automatic put_kind(input int k);
        bit ok;
        int tag;
        put(k == 0 || k == 2 || k == 4, k == 1 || k == 3 || k == 4, k >= 2, ok, tag);
    endtask

    task automatic issue(input int t);
        issue_valid = 1; issue_tag = 3'(t);
        @(negedge clk);
        issue_valid = 0;
        #1;
    endtask

    task automatic done(input int t);
        done_valid = 1; done_tag = 3'(t);
        @(negedge clk);
        done_valid = 0;
        #1;
    endtask

    // Kinds: 0 read, 1 write, 2 read barrier, 3 write barrier, 4 full barrier.
    function automatic logic [7:0] model(input int k0, input int k1, input int k2,
                                         input int k3, input bit na);
        int k [4];
        int f;
        logic [7:0] v;
        k[0] = k0; k[1] = k1; k[2] = k2; k[3] = k3;
        v = '0;
        f = 0;
        while (f < 4 && k[f] >= 2) f++;
        for (int i = f; i < 4; i++) begin
            bit blk;
            blk = 0;
            if (k[i] < 2) begin
                for (int j = f; j < i; j++) begin
                    if (k[i] == 1) begin
                        if (k[j] == 0 || k[j] == 1 || k[j] == 3 || k[j] == 4) blk = 1;
                    end else begin
                        if (k[j] == 2 || k[j] == 4) blk = 1;
                        if (k[j] == 1 && !na) blk = 1;
                        if (k[j] == 0)
                            for (int m = j + 1; m < i; m++)
                                if (k[m] != 0) blk = 1;
                    end
                end
                v[i] = !blk;
            end
        end
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit ok;
        int tag;
        do_reset();
        // R12 reset state
        chk("R12 lq_full", lq_full, 0);
        chk("R12 sq_full", sq_full, 0);
        chk("R12 can_issue", can_issue, 0);
        chk("R12 free_valid", free_valid, 0);

        // R11 zero read-budget setting uses the default of three
        z_valid = 1; z_ld = 1;
        repeat (2) @(negedge clk);
        #1;
        chk("R11 not full after two", z_lq_full, 0);
        @(negedge clk);
        z_valid = 0; z_ld = 0;
        #1;
        chk("R11 full after three", z_lq_full, 1);

        // R1 R2 budgets and tags
        do_reset();
        no_alias = 1;
        for (int i = 0; i < 4; i++) begin
            put(1, 0, 0, ok, tag);
            chk("R1 tag order", tag, i);
        end
        chk("R2 lq_full after four reads", lq_full, 1);
        put(1, 0, 0, ok, tag);
        chk("R2 read refused when full", ok, 0);
        put(0, 0, 0, ok, tag);
        chk("R1 classless request refused", ok, 0);
        put(0, 1, 0, ok, tag);
        chk("R2 write accepted while reads full", ok, 1);
        chk("R1 write tag", tag, 4);
        chk("R4 write held behind reads", can_issue, 8'h0F);

        // R10 R9 issue, completion and in-order free
        issue(4);
        chk("R10 blocked issue ignored", can_issue[4], 0);
        issue(0);
        chk("R10 permission drops after issue", can_issue[0], 0);
        done(0);
        chk("R9 head freed", free_valid, 1);
        chk("R9 head tag", free_tag, 0);
        issue(1); issue(2); issue(3);
        done(3);
        chk("R9 younger finished not freed", free_valid, 0);
        done(2);
        chk("R9 still waiting on oldest", free_valid, 0);
        done(1);
        chk("R9 free tag1", free_tag, 1);
        chk("R9 free valid tag1", free_valid, 1);
        step();
        chk("R9 free tag2", free_tag, 2);
        step();
        chk("R9 free tag3", free_tag, 3);
        step();
        chk("R9 queue drained of reads", free_valid, 0);
        chk("R4 write released", can_issue, 8'h10);
        chk("R2 read budget released", lq_full, 0);
        done(4);
        chk("R10 completion without issue ignored", free_valid, 0);
        put(0, 1, 0, ok, tag);
        chk("R3 second write held", can_issue, 8'h10);

        // R7 R8 barrier at head
        do_reset();
        put_kind(0); put_kind(2); put_kind(0);
        chk("R7 read waits for read barrier", can_issue, 8'h01);
        issue(0);
        done(0);
        chk("R9 head read freed", free_tag, 0);
        step();
        chk("R8 barrier freed at head", free_valid, 1);
        chk("R8 barrier tag", free_tag, 1);
        chk("R8 younger read released same cycle", can_issue, 8'h04);
        step();
        chk("R8 barrier gone", free_valid, 0);

        // R3 R4 R5 R6 R7 sweep over four-entry kind sequences
        for (int na = 0; na < 2; na++)
            for (int k0 = 0; k0 < 5; k0++)
                for (int k1 = 0; k1 < 5; k1++)
                    for (int k2 = 0; k2 < 5; k2++)
                        for (int k3 = 0; k3 < 5; k3++) begin
                            do_reset();
                            no_alias = na[0];
                            put_kind(k0); put_kind(k1); put_kind(k2); put_kind(k3);
                            step(); step(); step();
                            chk("R3/R4/R5/R6/R7 ordering sweep", can_issue,
                                model(k0, k1, k2, k3, na[0]));
                        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule